// File: doc/BRIEF.md
# Microcoded Conveyor Run Sequencer

This block starts and stops one conveyor motor. It is built as a microprogrammed machine, not as random gates. A three-bit state register selects one of four trip or pushbutton inputs through a condition multiplexer. The state value and the selected bit together form a four-bit address into a sixteen-word constant table. Each word of the table holds the next state and the levels for the run relay and the run lamp. On every clock edge the word at the current address is loaded into the state register and into the output flops.

The stored program walks four idle states. These test, in turn, the overheat trip, the emergency stop, the normal stop and the start button. A trip found during this walk sends the machine back to the first idle state. A start press in the last idle state enters the running loop. The running loop is three states that test overheat, emergency stop and normal stop in turn. A tested input that is active there drops the machine to idle and switches the relay and the lamp off on that same edge.

All inputs are active high. A reset synchronizer inside the block releases the active-low asynchronous reset on the clock. After the reset pin rises, the state stays at 001 for two more clock edges.

Top module: `conveyor_useq`

## Requirements
- R1: While reset is asserted, and for two clock edges after it is released, the state is 001 and both the relay and the lamp are off.
- R2: The state output never takes the value 000.
- R3: The condition tested depends only on the state: 001 and 101 test overheat, 010 and 110 test emergency stop, 011 and 111 test normal stop, and 100 tests start.
- R4: In states 001, 010 and 011, an inactive tested input advances the state by one. An active tested input returns the state to 001.
- R5: In state 100, an active start moves the state to 101 and turns the relay and the lamp on at the same edge. An inactive start returns the state to 001.
- R6: In states 101, 110 and 111, an active tested input returns the state to 001 on the next edge, with the relay and the lamp off from that edge on.
- R7: In the running loop, with the tested input inactive, the state goes 101 to 110 to 111 to 101, and the relay and the lamp stay on.
- R8: The relay and the lamp always agree. Both are on exactly when the state is 101, 110 or 111, and they change on the same edge as the state.
- R9: Inputs that the current state does not test have no effect on the next state or on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| overheat_i | input | 1 | Motor overheat trip, active high |
| estop_i | input | 1 | Emergency stop, active high |
| stop_i | input | 1 | Normal stop pushbutton, active high |
| start_i | input | 1 | Start pushbutton, active high |
| relay_o | output | 1 | Run relay drive |
| lamp_o | output | 1 | Run lamp drive |
| state_o | output | 3 | Current microprogram state |

## Verification
The hardest case to reach is a trip that lands on exactly the running state that tests it. Each running state looks at only one input, so the stimulus first enters the run loop with a start press. It then advances the machine with all inputs low until the state output shows the wanted state, and only then raises that one trip. The tests for ignored inputs work the same way. The machine is parked in a chosen state, every input that state does not test is raised, and one edge later the state and the outputs show whether only the tested input had any effect.

// File: rtl/conveyor_useq_pkg.sv
package conveyor_useq_pkg;
  localparam int STATE_W  = 3;
  localparam int N_COND   = 4;
  localparam int SEL_W    = $clog2(N_COND);
  localparam int ADDR_W   = STATE_W + 1;
  localparam int ROM_LEN  = 1 << ADDR_W;
  localparam int N_STATES = 1 << STATE_W;

  typedef logic [STATE_W-1:0] state_t;

  // condition vector bit positions
  localparam int C_OVERHEAT = 0;
  localparam int C_ESTOP    = 1;
  localparam int C_STOP     = 2;
  localparam int C_START    = 3;

  localparam state_t S_IDLE_OH  = 3'd1;
  localparam state_t S_IDLE_ES  = 3'd2;
  localparam state_t S_IDLE_SP  = 3'd3;
  localparam state_t S_ARM      = 3'd4;
  localparam state_t S_RUN_OH   = 3'd5;
  localparam state_t S_RUN_ES   = 3'd6;
  localparam state_t S_RUN_SP   = 3'd7;

  typedef struct packed {
    logic   relay;
    logic   lamp;
    state_t nxt;
  } uword_t;

  localparam int WORD_W = $bits(uword_t);

  function automatic logic [SEL_W-1:0] cond_of_state(state_t s);
    case (s)
      S_IDLE_OH, S_RUN_OH: return SEL_W'(C_OVERHEAT);
      S_IDLE_ES, S_RUN_ES: return SEL_W'(C_ESTOP);
      S_IDLE_SP, S_RUN_SP: return SEL_W'(C_STOP);
      default:             return SEL_W'(C_START);
    endcase
  endfunction

  function automatic uword_t mk(logic on, state_t n);
    uword_t w;
    w.relay = on;
    w.lamp  = on;
    w.nxt   = n;
    return w;
  endfunction

  // microprogram: address = {state, tested condition}
  function automatic uword_t ucode(logic [ADDR_W-1:0] a);
    state_t s;
    logic   c;
    s = a[ADDR_W-1:1];
    c = a[0];
    case (s)
      S_IDLE_OH: return c ? mk(1'b0, S_IDLE_OH) : mk(1'b0, S_IDLE_ES);
      S_IDLE_ES: return c ? mk(1'b0, S_IDLE_OH) : mk(1'b0, S_IDLE_SP);
      S_IDLE_SP: return c ? mk(1'b0, S_IDLE_OH) : mk(1'b0, S_ARM);
      S_ARM:     return c ? mk(1'b1, S_RUN_OH)  : mk(1'b0, S_IDLE_OH);
      S_RUN_OH:  return c ? mk(1'b0, S_IDLE_OH) : mk(1'b1, S_RUN_ES);
      S_RUN_ES:  return c ? mk(1'b0, S_IDLE_OH) : mk(1'b1, S_RUN_SP);
      S_RUN_SP:  return c ? mk(1'b0, S_IDLE_OH) : mk(1'b1, S_RUN_OH);
      default:   return mk(1'b0, S_IDLE_OH);
    endcase
  endfunction
endpackage

// File: rtl/conveyor_useq_rst_sync.sv
module conveyor_useq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/conveyor_useq_cond_mux.sv
module conveyor_useq_cond_mux
  import conveyor_useq_pkg::*;
(
  input  state_t            state_i,
  input  logic [N_COND-1:0] cond_i,
  output logic              cond_o
);
  logic [N_STATES-1:0] per_state;

  for (genvar s = 0; s < N_STATES; s++) begin : g_sel
    if (s == 0) begin : g_unused
      assign per_state[s] = 1'b0;
    end else begin : g_used
      localparam logic [SEL_W-1:0] SEL = cond_of_state(STATE_W'(s));
      assign per_state[s] = cond_i[SEL];
    end
  end

  assign cond_o = per_state[state_i];
endmodule

// File: rtl/conveyor_useq_rom.sv
module conveyor_useq_rom
  import conveyor_useq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output uword_t            word_o
);
  uword_t table_w [ROM_LEN];

  for (genvar a = 0; a < ROM_LEN; a++) begin : g_word
    assign table_w[a] = ucode(ADDR_W'(a));
  end

  assign word_o = table_w[addr_i];
endmodule

// File: rtl/conveyor_useq_state_reg.sv
module conveyor_useq_state_reg
  import conveyor_useq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  uword_t word_i,
  output state_t state_o,
  output logic   relay_o,
  output logic   lamp_o
);
  state_t state_q, state_d;
  logic   relay_q, relay_d;
  logic   lamp_q, lamp_d;
  logic   load_en;

  assign load_en = 1'b1;

  always_comb begin
    state_d = state_q;
    relay_d = relay_q;
    lamp_d  = lamp_q;
    if (load_en) begin
      state_d = word_i.nxt;
      relay_d = word_i.relay;
      lamp_d  = word_i.lamp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE_OH;
      relay_q <= 1'b0;
      lamp_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      relay_q <= relay_d;
      lamp_q  <= lamp_d;
    end
  end

  assign state_o = state_q;
  assign relay_o = relay_q;
  assign lamp_o  = lamp_q;
endmodule

// File: rtl/conveyor_useq.sv
module conveyor_useq
  import conveyor_useq_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         overheat_i,
  input  logic         estop_i,
  input  logic         stop_i,
  input  logic         start_i,
  output logic         relay_o,
  output logic         lamp_o,
  output logic [2:0]   state_o
);
  logic              rst_core_n;
  logic [N_COND-1:0] cond_vec;
  logic              cond_sel;
  logic [ADDR_W-1:0] rom_addr;
  uword_t            rom_word;
  state_t            cur_state;

  conveyor_useq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  always_comb begin
    cond_vec             = '0;
    cond_vec[C_OVERHEAT] = overheat_i;
    cond_vec[C_ESTOP]    = estop_i;
    cond_vec[C_STOP]     = stop_i;
    cond_vec[C_START]    = start_i;
  end

  conveyor_useq_cond_mux u_mux (
    .state_i (cur_state),
    .cond_i  (cond_vec),
    .cond_o  (cond_sel)
  );

  assign rom_addr = {cur_state, cond_sel};

  conveyor_useq_rom u_rom (
    .addr_i (rom_addr),
    .word_o (rom_word)
  );

  conveyor_useq_state_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .word_i  (rom_word),
    .state_o (cur_state),
    .relay_o (relay_o),
    .lamp_o  (lamp_o)
  );

  assign state_o = cur_state;
endmodule

// File: rtl/conveyor_useq_chk.sv
module conveyor_useq_chk (
  input logic       clk,
  input logic       rst_core_n,
  input logic       overheat_i,
  input logic       estop_i,
  input logic       stop_i,
  input logic       start_i,
  input logic       relay_o,
  input logic       lamp_o,
  input logic [2:0] state_o
);
  // R2
  state_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    state_o != 3'd0);

  // R8
  outs_agree_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    relay_o == lamp_o);

  // R8
  outs_vs_state_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    relay_o == (state_o >= 3'd5));

  // R4
  idle_trip_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((state_o == 3'd1 && overheat_i) || (state_o == 3'd2 && estop_i) ||
     (state_o == 3'd3 && stop_i)) |=> (state_o == 3'd1));

  // R4
  idle_advance_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state_o == 3'd2 && !estop_i) |=> (state_o == 3'd3));

  // R5
  arm_start_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state_o == 3'd4 && start_i) |=> (state_o == 3'd5 && relay_o));

  // R6
  run_trip_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((state_o == 3'd5 && overheat_i) || (state_o == 3'd6 && estop_i) ||
     (state_o == 3'd7 && stop_i)) |=> (state_o == 3'd1 && !relay_o));

  // R7
  run_wrap_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state_o == 3'd7 && !stop_i) |=> (state_o == 3'd5 && relay_o));
endmodule

bind conveyor_useq conveyor_useq_chk u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .overheat_i (overheat_i),
  .estop_i    (estop_i),
  .stop_i     (stop_i),
  .start_i    (start_i),
  .relay_o    (relay_o),
  .lamp_o     (lamp_o),
  .state_o    (state_o)
);

// File: tb/tb_conveyor_useq.sv
module tb_conveyor_useq;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, oh, es, sp, st;
  logic       relay, lamp;
  logic [2:0] state;
  int n_cmp = 0;
  int n_bad = 0;

  conveyor_useq dut (
    .clk(clk), .rst_n(rst_n), .overheat_i(oh), .estop_i(es),
    .stop_i(sp), .start_i(st), .relay_o(relay), .lamp_o(lamp), .state_o(state)
  );

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic all_low();
    oh = 0; es = 0; sp = 0; st = 0;
  endtask

  task automatic expect_now(string req, int s, bit on);
    chk({req, " state"}, state, s);
    chk({req, " relay"}, relay, on);
    chk({req, " lamp"}, lamp, on);
    chk("R2 nonzero", int'(state != 3'd0), 1);
  endtask

  task automatic do_reset();
    all_low();
    rst_n = 0;
    repeat (2) step();
    expect_now("R1 in reset", 1, 0);
    rst_n = 1;
    step();
    step();
  endtask

  task automatic go_running(int target);
    do_reset();
    st = 1;
    repeat (4) step();
    st = 0;
    for (int i = 0; i < 3 && state != target; i++) step();
  endtask

  task automatic t_reset();
    do_reset();
    expect_now("R1 after release", 1, 0);
  endtask

  task automatic t_startup();
    do_reset();
    st = 1;
    step(); expect_now("R4 1->2", 2, 0);
    step(); expect_now("R4 2->3", 3, 0);
    step(); expect_now("R4 3->4", 4, 0);
    step(); expect_now("R5 start R8", 5, 1);
  endtask

  task automatic t_run_loop();
    go_running(5);
    for (int i = 0; i < 2; i++) begin
      step(); expect_now("R7 5->6", 6, 1);
      step(); expect_now("R7 6->7", 7, 1);
      step(); expect_now("R7 7->5", 5, 1);
    end
  endtask

  task automatic t_run_trips();
    go_running(5); oh = 1; step(); expect_now("R6 overheat", 1, 0);
    go_running(6); es = 1; step(); expect_now("R6 estop", 1, 0);
    go_running(7); sp = 1; step(); expect_now("R6 stop", 1, 0);
  endtask

  task automatic t_idle_trips();
    do_reset(); oh = 1;
    repeat (3) step();
    expect_now("R4 overheat hold", 1, 0);
    do_reset(); step(); es = 1; step(); expect_now("R4 estop idle", 1, 0);
    do_reset(); step(); step(); sp = 1; step(); expect_now("R4 stop idle", 1, 0);
    do_reset(); repeat (3) step(); step(); expect_now("R5 no start", 1, 0);
  endtask

  task automatic t_unselected();
    do_reset(); es = 1; sp = 1; st = 1;
    step(); expect_now("R9 state1 ignores others R3", 2, 0);
    do_reset(); repeat (3) step(); sp = 1; es = 1; st = 1;
    step(); expect_now("R9 state4 ignores stops", 5, 1);
    go_running(5); es = 1; sp = 1; st = 1;
    step(); expect_now("R9 state5 ignores others", 6, 1);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0;
    all_low();
    #3;
    t_reset();
    t_startup();
    t_run_loop();
    t_run_trips();
    t_idle_trips();
    t_unselected();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule